// File: doc/BRIEF.md
# Bitmask Immediate Pattern Decoder

This block turns a packed 13-bit logical-immediate field into the 64-bit constant it stands for. The field has three parts: a size-select bit `in_n`, a 6-bit rotate amount `in_rot`, and a 6-bit length code `in_len`. The constant is built from identical elements of 2, 4, 8, 16, 32 or 64 bits. Each element holds a run of consecutive ones, and that run is rotated right inside the element. The block also flags field combinations that encode no constant, so that the surrounding decode logic can treat the instruction as undefined.

The caller presents one field per cycle, qualified by `in_valid`. One clock later the result appears on `out_mask` and `out_reserved`, with `out_valid` high. The block keeps no other state and applies no back-pressure.

Top module: `bitmask_imm_decoder`

## Requirements
- R1: The element size is 2^p, where p is the index of the highest set bit of the 7-bit value {in_n, ~in_len}. With in_n=1 the size is 64. With in_n=0, the leading bits of in_len pick the size: 0 gives 32, 10 gives 16, 110 gives 8, 1110 gives 4 and 11110 gives 2.
- R2: in_n=0 with in_len[5:1]=11111 is reserved, because p falls below 1.
- R3: For element size e, let s be in_len mod e. If s equals e-1, the encoding is reserved. This includes in_n=1 with in_len=63.
- R4: Inside one element, bits 0 to s are ones before rotation. The element is then rotated right by in_rot mod e.
- R5: The element value repeats in every e-bit slot of the 64-bit out_mask.
- R6: When out_reserved is 1, out_mask is all zeros.
- R7: out_valid is high exactly one cycle after a cycle with in_valid high, and low otherwise. A synchronous active-low reset clears out_valid, out_mask and out_reserved.
- R8: In a cycle with in_valid low, out_mask and out_reserved keep their values, whatever the field inputs do.
- R9: A non-reserved out_mask has between 1 and 63 ones, and its upper and lower 32-bit halves are equal whenever in_n was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Field strobe |
| in_n | input | 1 | Size-select bit |
| in_rot | input | 6 | Rotate amount |
| in_len | input | 6 | Element size prefix and run length minus one |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_mask | output | 64 | Decoded bit pattern |
| out_reserved | output | 1 | Encoding is reserved |

## Verification
The bound checker checks several properties on every cycle: the one-cycle valid timing, the zero mask on reserved results, both reserved-field conditions, the ones-count bounds, the half-word symmetry for in_n=0, and the hold of the outputs when there is no strobe. None of these properties can show that the right run length was rotated by the right amount. Only the bench can show that. It compares every one of the 8192 field combinations against a loop model, then adds directed rotate and replicate cases and random bursts with idle gaps.

// File: rtl/bmd_pkg.sv
// Package: shared sizing constants for the bitmask immediate decoder.
// Assumes the word width is a power of two given by its log2.
package bmd_pkg;
    localparam int WORD_LOG = 6;
    localparam int WORD_W   = 1 << WORD_LOG;
    localparam int LVL_W    = $clog2(WORD_LOG + 1);

    typedef struct packed {
        logic [WORD_W-1:0] mask;
        logic              reserved;
    } bmd_result_t;
endpackage

// File: rtl/bmd_size_detect.sv
// Finds the element-size level (log2 of the element width) from the
// size-select bit and the length code, by taking the highest set bit
// of {sel, ~len}. Levels below 1 are flagged as an invalid size.
// Assumes LOG_W >= 1.
module bmd_size_detect #(
    parameter int LOG_W = 6,
    parameter int LVL_W = $clog2(LOG_W + 1)
) (
    input  logic             sel,
    input  logic [LOG_W-1:0] len,
    output logic [LVL_W-1:0] level,
    output logic             size_bad
);
    localparam int VEC_W = LOG_W + 1;

    logic [VEC_W-1:0] probe;

    // Build the search vector from the select bit and the inverted length.
    always_comb probe = {sel, ~len};

    // Ascending scan, so the last hit is the highest set bit.
    always_comb begin
        level = '0;
        for (int i = 0; i < VEC_W; i++) begin
            if (probe[i]) level = LVL_W'(i);
        end
    end

    // Level 0 (one-bit elements or no set bit) encodes no pattern.
    always_comb size_bad = (level == '0);
endmodule

// File: rtl/bmd_lane_pattern.sv
// Produces the full replicated word for one fixed element size 2**LEVEL.
// Bit k is set when its position inside the element, shifted by the rotate
// amount, lands inside the run of s+1 ones; since the element size is a
// power of two the modulo is a plain truncation. It also reports whether
// the run field is all ones, which is reserved for this size.
module bmd_lane_pattern #(
    parameter int LOG_W = 6,
    parameter int LEVEL = 1
) (
    input  logic [LOG_W-1:0]     rot,
    input  logic [LOG_W-1:0]     len,
    output logic [(1<<LOG_W)-1:0] word,
    output logic                 run_full
);
    localparam int WORD_W = 1 << LOG_W;

    logic [LEVEL-1:0] run_s;
    logic [LEVEL-1:0] rot_r;

    // Reduce the run and rotate fields to the element width.
    always_comb begin
        run_s = len[LEVEL-1:0];
        rot_r = rot[LEVEL-1:0];
    end

    // Rotated run, repeated over every slot of the word.
    always_comb begin : fill_bits
        logic [LEVEL-1:0] slot_pos;
        logic [LEVEL-1:0] src_pos;
        for (int k = 0; k < WORD_W; k++) begin
            slot_pos = LEVEL'(k);
            src_pos  = slot_pos + rot_r;
            word[k]  = (src_pos <= run_s);
        end
    end

    // A run covering the whole element is not a valid encoding.
    always_comb run_full = &run_s;
endmodule

// File: rtl/bitmask_imm_decoder.sv
// Top level: decodes {in_n, in_rot, in_len} into a 64-bit pattern made of
// repeated rotated runs of ones, flags reserved encodings and registers the
// result one cycle after the strobe. Reserved encodings give a zero mask.
// Assumes a single clock and a synchronous active-low reset.
module bitmask_imm_decoder #(
    parameter int LOG_W  = bmd_pkg::WORD_LOG,
    parameter int WORD_W = 1 << LOG_W,
    parameter int LVL_W  = $clog2(LOG_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_n,
    input  logic [LOG_W-1:0]  in_rot,
    input  logic [LOG_W-1:0]  in_len,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_mask,
    output logic              out_reserved
);
    logic [LVL_W-1:0]  level;
    logic              size_bad;
    logic [WORD_W-1:0] cand_word [LOG_W+1];
    logic              cand_full [LOG_W+1];
    logic [WORD_W-1:0] pick_word;
    logic              pick_full;
    logic              resv_c;
    logic [WORD_W-1:0] mask_c;

    bmd_size_detect #(.LOG_W(LOG_W), .LVL_W(LVL_W)) u_size (
        .sel      (in_n),
        .len      (in_len),
        .level    (level),
        .size_bad (size_bad)
    );

    // Level 0 never selects a pattern; tie its slot off.
    always_comb begin
        cand_word[0] = '0;
        cand_full[0] = 1'b1;
    end

    // One pattern generator for each legal element size.
    for (genvar lv = 1; lv <= LOG_W; lv++) begin : g_lane
        bmd_lane_pattern #(.LOG_W(LOG_W), .LEVEL(lv)) u_lane (
            .rot      (in_rot),
            .len      (in_len),
            .word     (cand_word[lv]),
            .run_full (cand_full[lv])
        );
    end

    // Select the candidate for the detected element size.
    always_comb begin
        pick_word = '0;
        pick_full = 1'b1;
        for (int lv = 0; lv <= LOG_W; lv++) begin
            if (level == LVL_W'(lv)) begin
                pick_word = cand_word[lv];
                pick_full = cand_full[lv];
            end
        end
    end

    // Combine both reserved checks and zero the mask when reserved.
    always_comb begin
        resv_c = size_bad | pick_full;
        mask_c = resv_c ? '0 : pick_word;
    end

    // Output register: valid follows the strobe, data loads only on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_mask     <= '0;
            out_reserved <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask     <= mask_c;
                out_reserved <= resv_c;
            end
        end
    end
endmodule

// File: rtl/bmd_checker.sv
// Checker for bitmask_imm_decoder: timing, reserved handling, mask shape
// and hold behaviour, evaluated on every clock outside reset.
module bmd_checker #(
    parameter int LOG_W  = 6,
    parameter int WORD_W = 1 << LOG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_n,
    input logic [LOG_W-1:0]  in_rot,
    input logic [LOG_W-1:0]  in_len,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_mask,
    input logic              out_reserved
);
    localparam int HALF = WORD_W / 2;

    a_r7_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r7_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r6_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_reserved) |-> (out_mask == '0));
    a_r2_small_size: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_n && (&in_len[LOG_W-1:1])) |=> out_reserved);
    a_r3_full_run: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_n && (&in_len)) |=> out_reserved);
    a_r9_ones_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_reserved) |->
        ($countones(out_mask) >= 1 && $countones(out_mask) <= WORD_W - 1));
    a_r9_half_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_n) |=>
        (out_reserved || out_mask[WORD_W-1:HALF] == out_mask[HALF-1:0]));
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_mask) && $stable(out_reserved)));
endmodule

bind bitmask_imm_decoder bmd_checker #(.LOG_W(LOG_W), .WORD_W(WORD_W)) u_bmd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_n         (in_n),
    .in_rot       (in_rot),
    .in_len       (in_len),
    .out_valid    (out_valid),
    .out_mask     (out_mask),
    .out_reserved (out_reserved)
);

// File: tb/bitmask_imm_decoder_test.sv
module bitmask_imm_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_n = 1'b0;
    logic [5:0]  in_rot = '0;
    logic [5:0]  in_len = '0;
    logic        out_valid;
    logic [63:0] out_mask;
    logic        out_reserved;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bitmask_imm_decoder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_n(in_n),
        .in_rot(in_rot), .in_len(in_len), .out_valid(out_valid),
        .out_mask(out_mask), .out_reserved(out_reserved)
    );

    // Loop model: build the run, rotate one step at a time, then tile.
    function automatic void model(input bit n, input bit [5:0] r, input bit [5:0] s,
                                  output bit [63:0] m, output bit res);
        int p, e, sl, rl;
        bit [63:0] el;
        bit lsb;
        m = '0; res = 1'b0;
        if (n) p = 6;
        else begin
            p = -1;
            for (int i = 5; i >= 0; i--) if (!s[i]) begin p = i; break; end
        end
        if (p < 1) begin res = 1'b1; return; end
        e = 1 << p;
        sl = int'(s) % e;
        rl = int'(r) % e;
        if (sl == e - 1) begin res = 1'b1; return; end
        el = '0;
        for (int i = 0; i <= sl; i++) el[i] = 1'b1;
        for (int t = 0; t < rl; t++) begin
            lsb = el[0];
            el = el >> 1;
            el[e-1] = lsb;
        end
        for (int k = 0; k < 64; k++) m[k] = el[k % e];
    endfunction

    task automatic check(input string req, input bit [63:0] em, input bit er, input bit ev);
        tests++;
        if (out_mask !== em || out_reserved !== er || out_valid !== ev) begin
            fails++;
            $display("FAIL %s: got mask=%h res=%b valid=%b, expected mask=%h res=%b valid=%b",
                     req, out_mask, out_reserved, out_valid, em, er, ev);
        end
    endtask

    task automatic apply(input bit n, input bit [5:0] r, input bit [5:0] s);
        @(negedge clk);
        in_n = n; in_rot = r; in_len = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic apply_check(input string req, input bit n, input bit [5:0] r,
                               input bit [5:0] s);
        bit [63:0] em;
        bit er;
        model(n, r, s, em, er);
        apply(n, r, s);
        check(req, em, er, 1'b1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R7: watchdog expired, got running, expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        bit [63:0] hold_m;
        bit hold_r;
        int seed;
        seed = 20240611;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 reset", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // Directed corner cases
        apply_check("R1 R4 size64 single", 1'b1, 6'd0, 6'd0);
        check("R1 size64 value", 64'h1, 1'b0, 1'b1);
        apply_check("R5 size2", 1'b0, 6'd0, 6'b111100);
        check("R5 size2 value", 64'h5555_5555_5555_5555, 1'b0, 1'b1);
        apply_check("R4 size2 rot", 1'b0, 6'd1, 6'b111100);
        check("R4 size2 rot value", 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, 1'b1);
        apply_check("R3 R6 size64 full run", 1'b1, 6'd5, 6'd63);
        check("R3 R6 value", 64'h0, 1'b1, 1'b1);
        apply_check("R2 R6 11111x", 1'b0, 6'd3, 6'b111110);
        check("R2 value", 64'h0, 1'b1, 1'b1);
        apply_check("R1 size32", 1'b0, 6'd0, 6'd0);
        check("R1 size32 value", 64'h0000_0001_0000_0001, 1'b0, 1'b1);
        apply_check("R4 size32 rot mod", 1'b0, 6'd33, 6'd0);
        check("R4 rot mod value", 64'h8000_0000_8000_0000, 1'b0, 1'b1);
        apply_check("R3 size32 full run", 1'b0, 6'd0, 6'b011111);
        check("R3 size32 value", 64'h0, 1'b1, 1'b1);
        apply_check("R1 size8", 1'b0, 6'd2, 6'b110010);
        check("R1 R5 size8 value", 64'hC1C1_C1C1_C1C1_C1C1, 1'b0, 1'b1);

        // R8: hold with no strobe while the fields move
        apply_check("R8 setup", 1'b1, 6'd7, 6'd20);
        hold_m = out_mask; hold_r = out_reserved;
        for (int i = 0; i < 3; i++) begin
            in_n = ~in_n; in_rot = in_rot + 6'd9; in_len = in_len ^ 6'h2A;
            @(negedge clk);
            check("R8 R7 hold", hold_m, hold_r, 1'b0);
        end

        // Exhaustive sweep: R1 R2 R3 R4 R5 R6 R9
        for (int v = 0; v < 8192; v++) begin
            apply_check("R1-sweep R4 R5", v[12], v[11:6], v[5:0]);
        end

        // Random bursts with idle gaps
        for (int i = 0; i < 600; i++) begin
            bit [12:0] f;
            f = 13'($urandom);
            apply_check("R4 R5 random", f[12], f[11:6], f[5:0]);
            if ($urandom_range(0, 3) == 0) begin
                hold_m = out_mask; hold_r = out_reserved;
                @(negedge clk);
                check("R8 random gap", hold_m, hold_r, 1'b0);
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule